// File: doc/BRIEF.md
# Per-Packet Symbol Error Counter

This block keeps a running tally of receive windows on a 100 Mb/s Ethernet link in which the line decoder reported at least one invalid code symbol. A window is either one packet, from its start marker to its end marker, or one idle gap between packets. However many bad symbols arrive inside a window, the tally rises by one at most. The tally is 16 bits wide and wraps to zero rather than saturating. When the link runs at 10 Mb/s the tally is held.

Management logic reads the tally through a simple register read port. A read returns the value one cycle later and leaves the count as it was. The port also accepts writes, which are discarded, because the register is read-only. A hardware reset (asynchronous, active low) and a soft reset (synchronous, active high) both return the tally and the window state to zero. All inputs are synchronous to the single receive clock, and at most one symbol strobe arrives per clock.

Top module: `symerr_counter`

## Requirements
- R1: A symbol error is a cycle with `symValid`=1 and `symInvalid`=1. With `linkIs100`=1, the first symbol error of a window raises the count by one. This holds for packet windows and for idle windows alike.
- R2: Further symbol errors in the same window leave the count unchanged. A packet window opens when `pktStart`=1. An idle window opens in the cycle after `pktEnd`=1.
- R3: The count is 16 bits wide. One increment from 16'hFFFF gives 16'h0000.
- R4: A symbol error in the same cycle as `pktStart` belongs to the new packet and counts when that packet has no earlier error. A symbol error in the same cycle as `pktEnd` belongs to the ending packet. The idle window that follows counts its own first error.
- R5: While `linkIs100`=0 the count never changes.
- R6: `hwRstN`=0 (asynchronous) and `softRst`=1 (applied at the clock edge) each clear the count to 0 and reopen the current window, so the next symbol error counts.
- R7: `rdEn`=1 at a clock edge loads `rdData` with the count as it stood before that edge and raises `rdValid` for one cycle. An increment at the same edge is not lost, and a read never clears the count.
- R8: `wrEn`=1, with any `wrData`, has no effect on the count.
- R9: `symInvalid`=1 while `symValid`=0 is not a symbol error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| hwRstN | input | 1 | Hardware reset, asynchronous, active low |
| softRst | input | 1 | Soft reset, synchronous, active high |
| symValid | input | 1 | A decoded symbol is present this cycle |
| symInvalid | input | 1 | The present symbol is not a valid code group |
| pktStart | input | 1 | First cycle of a packet |
| pktEnd | input | 1 | Last cycle of a packet |
| linkIs100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe (ignored) |
| wrData | input | 16 | Register write data (ignored) |
| rdData | output | 16 | Count captured by the last read |
| rdValid | output | 1 | `rdData` was loaded at the last edge |

## Verification
A symbol error updates the count at the same clock edge that samples it. The count can only be seen through a read, and `rdData` takes the pre-edge count at the edge where `rdEn` is high. So a read issued in the cycle after an error shows that error, and a read issued in the same cycle as the error does not. The bench drives all inputs on the falling edge. It issues a read as its own one-cycle strobe and samples `rdData` and `rdValid` at the next falling edge, half a period after the loading edge. Every expected value then follows from the order of the issued cycles alone.

// File: rtl/symerr_pkg.sv
package symerr_pkg;
  // Strobes from the window control to the counting datapath
  typedef struct packed {
    logic incEn;    // advance the count at this edge
    logic clearAll; // synchronous clear of the count
  } dpStrobes_t;
endpackage

// File: rtl/symerr_ctrl.sv
module symerr_ctrl
  import symerr_pkg::*;
(
  input  logic       clk,
  input  logic       hwRstN,
  input  logic       softRst,
  input  logic       symValid,
  input  logic       symInvalid,
  input  logic       pktStart,
  input  logic       pktEnd,
  input  logic       linkIs100,
  output dpStrobes_t strobes
);
  logic symErr;
  logic seenErr;      // window already charged
  logic windowFresh;
  logic seenErrNext;

  always_comb begin
    symErr      = symValid & symInvalid;
    // a start marker opens a new window in the same cycle
    windowFresh = pktStart | ~seenErr;
    strobes.incEn    = symErr & windowFresh & linkIs100 & ~softRst;
    strobes.clearAll = softRst;
  end

  always_comb begin
    if (softRst)       seenErrNext = 1'b0;
    else if (pktStart) seenErrNext = symErr;
    else if (pktEnd)   seenErrNext = 1'b0; // idle window begins next cycle
    else if (symErr)   seenErrNext = 1'b1;
    else               seenErrNext = seenErr;
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) seenErr <= 1'b0;
    else         seenErr <= seenErrNext;
  end

  // R2: a charged window accepts no further increment until it is reopened
  p_once_per_window_r2: assert property (@(posedge clk) disable iff (!hwRstN)
    (seenErr && !pktStart) |-> !strobes.incEn);

  // R6: soft reset reopens the window
  p_soft_reopens_r6: assert property (@(posedge clk) disable iff (!hwRstN)
    softRst |=> !seenErr);

  // R9: an invalid flag without a symbol strobe never charges a window
  p_needs_strobe_r9: assert property (@(posedge clk) disable iff (!hwRstN)
    (!symValid && !pktStart && !pktEnd && !softRst) |=> (seenErr == $past(seenErr)));
endmodule

// File: rtl/symerr_dp.sv
module symerr_dp
  import symerr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             hwRstN,
  input  dpStrobes_t       strobes,
  input  logic             rdEn,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countNext;

  always_comb begin
    if (strobes.clearAll)   countNext = '0;
    else if (strobes.incEn) countNext = countQ + CNT_ONE; // wraps naturally
    else                    countNext = countQ;
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) countQ <= '0;
    else         countQ <= countNext;
  end

  // read capture: sees the count as it stood before this edge
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= countQ;
    end
  end

  // R3: the count only ever steps by one, modulo 2^CNT_W
  p_step_one_r3: assert property (@(posedge clk) disable iff (!hwRstN)
    (!$past(strobes.clearAll) && countQ != $past(countQ)) |-> countQ == $past(countQ) + CNT_ONE);

  // R6: soft clear empties the count
  p_clear_on_reset_r6: assert property (@(posedge clk) disable iff (!hwRstN)
    strobes.clearAll |=> countQ == '0);

  // R7: a read returns the pre-edge count and leaves the count alone
  p_read_prior_r7: assert property (@(posedge clk) disable iff (!hwRstN)
    rdEn |=> (rdValid && rdData == $past(countQ)));
endmodule

// File: rtl/symerr_counter.sv
module symerr_counter
  import symerr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             hwRstN,
  input  logic             softRst,
  input  logic             symValid,
  input  logic             symInvalid,
  input  logic             pktStart,
  input  logic             pktEnd,
  input  logic             linkIs100,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid
);
  dpStrobes_t       strobes;
  logic [CNT_W-1:0] countQ;

  symerr_ctrl u_ctrl (
    .clk        (clk),
    .hwRstN     (hwRstN),
    .softRst    (softRst),
    .symValid   (symValid),
    .symInvalid (symInvalid),
    .pktStart   (pktStart),
    .pktEnd     (pktEnd),
    .linkIs100  (linkIs100),
    .strobes    (strobes)
  );

  symerr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .hwRstN  (hwRstN),
    .strobes (strobes),
    .rdEn    (rdEn),
    .countQ  (countQ),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  // R5: at 10 Mb/s the count holds
  p_hold_at_10m_r5: assert property (@(posedge clk) disable iff (!hwRstN)
    (!linkIs100 && !softRst) |=> countQ == $past(countQ));

  // R8: a write, whatever its data, is not stored
  p_write_ignored_r8: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && wrData != countQ && !strobes.incEn && !softRst) |=> countQ == $past(countQ));
endmodule

// File: tb/symerr_counter_tb.sv
`timescale 1ns/1ps
module symerr_counter_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         hwRstN = 1'b0;
  logic         softRst = 1'b0;
  logic         symValid = 1'b0;
  logic         symInvalid = 1'b0;
  logic         pktStart = 1'b0;
  logic         pktEnd = 1'b0;
  logic         linkIs100 = 1'b1;
  logic         rdEn = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         rdValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  symerr_counter #(.CNT_W(W)) u_dut (
    .clk(clk), .hwRstN(hwRstN), .softRst(softRst),
    .symValid(symValid), .symInvalid(symInvalid),
    .pktStart(pktStart), .pktEnd(pktEnd), .linkIs100(linkIs100),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with the given symbol/framing inputs, then back to quiet
  task automatic cyc(input logic v, input logic bad, input logic ps, input logic pe);
    symValid = v; symInvalid = bad; pktStart = ps; pktEnd = pe;
    @(negedge clk);
    symValid = 1'b0; symInvalid = 1'b0; pktStart = 1'b0; pktEnd = 1'b0;
  endtask

  task automatic readCount(input string req, input logic [W-1:0] exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check({req, " rdValid"}, {{(W-1){1'b0}}, rdValid}, 1);
    check(req, rdData, exp);
  endtask

  task automatic doSoftReset();
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
  endtask

  task automatic t_reset();
    readCount("R6 count after hardware reset", 0);
  endtask

  task automatic t_basic();       // R1, R9
    cyc(1, 1, 0, 0);              // idle error
    readCount("R1 idle error counted", 1);
    cyc(0, 0, 1, 0);              // packet opens
    cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 1);
    readCount("R1 packet error counted", 2);
    cyc(0, 1, 0, 0);              // invalid flag without strobe (idle window open)
    readCount("R9 flag without strobe ignored", 2);
    cyc(1, 1, 0, 0);              // same idle window still fresh
    readCount("R9 idle window still open", 3);
  endtask

  task automatic t_once();        // R2
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 1);
    readCount("R2 three errors in one packet", 4);
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    readCount("R2 burst in one idle gap", 5);
  endtask

  task automatic t_edges();       // R4
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 0);              // charges packet A -> 6
    cyc(1, 1, 1, 0);              // error with start of packet B -> 7
    cyc(1, 1, 0, 0);              // same packet B, no count
    cyc(1, 0, 0, 1);
    readCount("R4 error at start marker", 7);
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 1);              // error on end marker, packet clean -> 8
    cyc(1, 1, 0, 0);              // following idle window -> 9
    readCount("R4 error at end marker then idle", 9);
  endtask

  task automatic t_speed();       // R5
    linkIs100 = 1'b0;
    cyc(0, 0, 1, 0);
    cyc(1, 1, 0, 0); cyc(1, 1, 1, 0); cyc(1, 1, 0, 1);
    readCount("R5 no count at 10 Mb/s", 9);
    linkIs100 = 1'b1;
    cyc(1, 1, 1, 0);              // fresh packet at 100 Mb/s -> 10
    cyc(0, 0, 0, 1);
    readCount("R5 counting resumes at 100 Mb/s", 10);
  endtask

  task automatic t_read();        // R7, R8
    readCount("R7 read does not clear", 10);
    readCount("R7 second read same value", 10);
    rdEn = 1'b1; symValid = 1'b1; symInvalid = 1'b1;   // idle window fresh
    @(negedge clk);
    rdEn = 1'b0; symValid = 1'b0; symInvalid = 1'b0;
    check("R7 read with increment returns old value", rdData, 10);
    readCount("R7 increment kept", 11);
    wrEn = 1'b1; wrData = '0;
    @(negedge clk);
    wrData = 16'h1234;
    @(negedge clk);
    wrEn = 1'b0;
    readCount("R8 writes ignored", 11);
  endtask

  task automatic t_softReset();   // R6
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 0);              // packet charged -> 12
    doSoftReset();
    readCount("R6 soft reset clears count", 0);
    cyc(1, 1, 0, 0);              // same packet, window reopened -> 1
    readCount("R6 soft reset reopens window", 1);
    cyc(1, 0, 0, 1);
  endtask

  task automatic t_wrap();        // R3
    doSoftReset();
    symValid = 1'b1; symInvalid = 1'b1; pktStart = 1'b1;
    repeat (65535) @(negedge clk);
    symValid = 1'b0; symInvalid = 1'b0; pktStart = 1'b0;
    readCount("R3 count reaches all ones", 16'hFFFF);
    cyc(1, 1, 1, 0);
    readCount("R3 wrap to zero", 16'h0000);
  endtask

  task automatic t_hwReset();     // R6
    cyc(1, 1, 1, 0);
    readCount("R6 pre hard reset", 1);
    #1 hwRstN = 1'b0;
    #3 hwRstN = 1'b1;
    @(negedge clk);
    readCount("R6 hardware reset clears count", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hwRstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_once();
    t_edges();
    t_speed();
    t_read();
    t_softReset();
    t_wrap();
    t_hwReset();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule